// File: doc/BRIEF.md
# Byte-Lane Write Enable Logic

This block sits in front of a 32-bit word memory made of four 8-bit byte lanes. On every rising clock edge it decides which lanes get written. It also captures the input word in the same register stage, so the array always writes a word together with the lane mask that belongs to it. The lane controls are an active-low whole-word write, an active-low gate that admits the per-lane selects, four active-low per-lane selects and the active-low processor address strobe. The whole-word write overrides everything else. A low address strobe cancels per-lane writes.

The registered lane strobe and the captured word go straight to the array. A merge stage takes the array's current word and builds the word to store back: each enabled lane takes the captured byte, and each disabled lane keeps its old byte. A separate output goes high whenever any lane write is in progress, so the surrounding logic can turn the data drivers off.

Top module: `bw_byte_write_ctl`

## Requirements
- R1: While `rst_n` is low, `wr_strobe` is 0, `wr_data` is 0 and `out_off` is 0.
- R2: If `gw_n` is 0 at a rising edge, all four bits of `wr_strobe` are 1 after that edge. This holds whatever the values of `bgate_n`, `bsel_n` and `adsp_n`.
- R3: If `gw_n`=1, `bgate_n`=0 and `adsp_n`=1 at an edge, then after that edge `wr_strobe[i]` is 1 exactly when `bsel_n[i]` was 0.
- R4: If `gw_n`=1 and `bgate_n`=1 at an edge, the selects are ignored and `wr_strobe` is 0 after that edge.
- R5: If `gw_n`=1 and `adsp_n`=0 at an edge, no lane is written: `wr_strobe` is 0 after that edge.
- R6: Lane i covers data bits 8i+7 down to 8i: `bsel_n[0]` selects bits 7:0 and `bsel_n[3]` selects bits 31:24. Where `wr_strobe[i]` is 1, lane i of `arr_d` equals lane i of `wr_data`. Where it is 0, lane i of `arr_d` equals lane i of `arr_q`.
- R7: `out_off` is 1 in exactly those cycles in which at least one bit of `wr_strobe` is 1.
- R8: `wr_data` holds the `din` sampled at the same edge that produced `wr_strobe`.
- R9: When `wr_strobe` is 0, `arr_d` equals `arr_q`, so the array is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_n | input | 1 | Whole-word write, active low |
| bgate_n | input | 1 | Gate that admits the per-lane selects, active low |
| bsel_n | input | 4 | Per-lane write selects, active low; bit i is lane i |
| adsp_n | input | 1 | Processor address strobe, active low; cancels per-lane writes |
| din | input | 32 | Write data |
| arr_q | input | 32 | Current array word at the write address |
| wr_strobe | output | 4 | Registered lane write strobe, active high |
| wr_data | output | 32 | Captured write data |
| out_off | output | 1 | High while any lane write is active |
| arr_d | output | 32 | Merged word to store into the array |

## Verification
Each control and data value applied before a rising edge must appear on `wr_strobe`, `wr_data` and `out_off` one cycle later, after that single register stage. `arr_d` follows `wr_strobe`, `wr_data` and `arr_q` within the same cycle, with no added delay. The bench changes inputs on falling edges and samples a quarter period after the rising edge that captures them. Expected strobes come from a table written from the requirements, and expected merged words are rebuilt lane by lane in the bench.

// File: rtl/bw_lane_decode.sv
module bw_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bgate_n,
  input  logic             adsp_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_req,
  output logic             gw_hit,
  output logic             byte_path_open
);
  // Lane request for one edge: whole-word write wins, then gated selects.
  function automatic logic [LANES-1:0] decode_lanes(
    input logic gw_l, input logic gate_l, input logic strobe_l,
    input logic [LANES-1:0] sel_l);
    logic [LANES-1:0] r;
    if (!gw_l)                   r = '1;
    else if (!gate_l && strobe_l) r = ~sel_l;
    else                          r = '0;
    return r;
  endfunction

  assign gw_hit         = !gw_n;
  assign byte_path_open = !bgate_n && adsp_n;
  assign lane_req       = decode_lanes(gw_n, bgate_n, adsp_n, bsel_n);
endmodule

// File: rtl/bw_capture_reg.sv
module bw_capture_reg #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_req,
  input  logic [DATA_W-1:0] din,
  input  logic              gw_hit,
  input  logic              byte_path_open,
  output logic [LANES-1:0]  wr_strobe,
  output logic [DATA_W-1:0] wr_data
);
  // Strobe and data share one register stage so they stay paired.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= lane_req;
      wr_data   <= din;
    end
  end

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    gw_hit |=> (wr_strobe == {LANES{1'b1}}));  // R2
  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_hit && !byte_path_open) |=> (wr_strobe == '0));  // R4
  AST_DATA_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_data == $past(din)));  // R8
endmodule

// File: rtl/bw_lane_merge.sv
module bw_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] arr_q,
  output logic [DATA_W-1:0] arr_d
);
  // One lane: new byte when enabled, else the stored byte.
  function automatic logic [LANE_W-1:0] pick_lane(
    input logic en, input logic [LANE_W-1:0] nw, input logic [LANE_W-1:0] old);
    return en ? nw : old;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign arr_d[g*LANE_W +: LANE_W] =
      pick_lane(wr_strobe[g], wr_data[g*LANE_W +: LANE_W], arr_q[g*LANE_W +: LANE_W]);
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe == '0) |-> (arr_d == arr_q));  // R9
endmodule

// File: rtl/bw_byte_write_ctl.sv
module bw_byte_write_ctl #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gw_n,
  input  logic              bgate_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              adsp_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] arr_q,
  output logic [LANES-1:0]  wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_off,
  output logic [DATA_W-1:0] arr_d
);
  logic [LANES-1:0] lane_req;
  logic             gw_hit;
  logic             byte_path_open;

  bw_lane_decode #(.LANES(LANES)) u_decode (
    .gw_n(gw_n), .bgate_n(bgate_n), .adsp_n(adsp_n), .bsel_n(bsel_n),
    .lane_req(lane_req), .gw_hit(gw_hit), .byte_path_open(byte_path_open));

  bw_capture_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .lane_req(lane_req), .din(din),
    .gw_hit(gw_hit), .byte_path_open(byte_path_open),
    .wr_strobe(wr_strobe), .wr_data(wr_data));

  bw_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .arr_q(arr_q), .arr_d(arr_d));

  assign out_off = |wr_strobe;

  AST_STROBE_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && !adsp_n) |=> (wr_strobe == '0));  // R5
  AST_GW_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |=> out_off);  // R7
  AST_OPEN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && !bgate_n && adsp_n) |=> (wr_strobe == ~$past(bsel_n)));  // R3
endmodule

// File: tb/bw_byte_write_ctl_tb.sv
module bw_byte_write_ctl_tb;
  localparam int PERIOD = 10;
  localparam int NV = 10;
  localparam logic [31:0] OLD = 32'hA5C3_5A3C;
  // fields: gw_n, bgate_n, adsp_n, bsel_n[3:0], din[31:0], expected strobe[3:0]
  localparam logic [42:0] VEC [NV] = '{
    {3'b111, 4'b0000, 32'h1111_1111, 4'b0000},  // R4 gate high
    {3'b011, 4'b1111, 32'h2222_2222, 4'b1111},  // R2
    {3'b101, 4'b1110, 32'h3333_3333, 4'b0001},  // R3 lane 0
    {3'b101, 4'b0101, 32'h4444_4444, 4'b1010},  // R3 lanes 1,3
    {3'b100, 4'b0000, 32'h5555_5555, 4'b0000},  // R5
    {3'b000, 4'b1010, 32'h6666_6666, 4'b1111},  // R2 strobe does not cancel
    {3'b101, 4'b0111, 32'h7777_7777, 4'b1000},  // R3 lane 3
    {3'b101, 4'b1111, 32'h8888_8888, 4'b0000},  // R9 no lane
    {3'b110, 4'b0000, 32'h9999_9999, 4'b0000},  // R4/R5
    {3'b001, 4'b0000, 32'hAAAA_AAAA, 4'b1111}   // R2
  };

  logic clk = 0, rst_n = 0, gw_n = 1, bgate_n = 1, adsp_n = 1;
  logic [3:0] bsel_n = '1;
  logic [31:0] din = '0, arr_q = OLD;
  logic [3:0] wr_strobe;
  logic [31:0] wr_data, arr_d;
  logic out_off;
  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bw_byte_write_ctl u_dut (.clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bgate_n(bgate_n),
    .bsel_n(bsel_n), .adsp_n(adsp_n), .din(din), .arr_q(arr_q),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .out_off(out_off), .arr_d(arr_d));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merged(input logic [3:0] s, input logic [31:0] nw,
                                         input logic [31:0] old);
    logic [31:0] m = old;
    for (int b = 0; b < 32; b++) if (s[b/8]) m[b] = nw[b];
    return m;
  endfunction

  task automatic apply(input logic [42:0] v);
    @(negedge clk);
    {gw_n, bgate_n, adsp_n, bsel_n, din} = v[42:4];
    @(posedge clk); #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD*2000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    gw_n = 0; din = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R1 strobe", {28'd0, wr_strobe}, 32'd0);
    chk("R1 data", wr_data, 32'd0);
    chk("R1 out_off", {31'd0, out_off}, 32'd0);
    @(negedge clk); rst_n = 1; gw_n = 1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk("R2/R3/R4/R5 strobe", {28'd0, wr_strobe}, {28'd0, VEC[i][3:0]});
      chk("R8 data", wr_data, VEC[i][35:4]);
      chk("R7 out_off", {31'd0, out_off}, {31'd0, VEC[i][3:0] != 4'd0});
      chk("R6/R9 merge", arr_d, merged(VEC[i][3:0], VEC[i][35:4], OLD));
    end
    // R6 single lanes with a changed array word
    arr_q = 32'h0123_4567;
    for (int l = 0; l < 4; l++) begin
      apply({3'b101, ~(4'b1 << l), 32'hFEDC_BA98, 4'b0});
      chk("R6 lane", arr_d, merged(4'b1 << l, 32'hFEDC_BA98, 32'h0123_4567));
    end
    // R9 idle cycle with array word changing
    apply({3'b111, 4'b0000, 32'hDEAD_BEEF, 4'b0});
    arr_q = 32'h7654_3210; #1;
    chk("R9 hold", arr_d, 32'h7654_3210);
    // R1 reset in mid-write
    apply({3'b011, 4'b0000, 32'hCAFE_F00D, 4'b0});
    rst_n = 0; #1;
    chk("R1 mid strobe", {28'd0, wr_strobe}, 32'd0);
    chk("R1 mid out_off", {31'd0, out_off}, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule